// File: doc/BRIEF.md
# Wide Multiply-Subtract Execution Unit

This unit takes three unsigned 64-bit operands `a`, `b` and `c`. It computes `c`, zero-extended to 128 bits, minus the full 128-bit product `a*b`. The 128-bit difference is split into two 64-bit words. The low word is meant for the primary destination register. The high word is meant for a second destination register.

The unit also works out the index of that second destination from the primary index. In scalar mode the second register is the next one. In vector mode it sits one vector length further on. Index arithmetic wraps within a 128-entry register space.

The whole operation takes one clock: results and a valid flag appear on the cycle after the input strobe. Register-file access, decode and vector loop control belong to the surrounding pipeline.

Top module: `wide_msub_unit`

## Requirements
- R1: The product of `op_a` and `op_b` is formed as a full 128-bit unsigned product. Both operands are treated as unsigned, so no sign extension takes place.
- R2: The result is `{64'b0, op_c}` minus the product, taken modulo 2^128. No flag or overflow indication exists.
- R3: `lo_word` carries bits [63:0] of the 128-bit difference, where bit 0 is the least significant bit.
- R4: `hi_word` carries bits [127:64] of the 128-bit difference.
- R5: When `vec_mode` is 0 (scalar), `dst2_idx` equals `dst_idx + 1` modulo 128.
- R6: When `vec_mode` is 1 (vector), `dst2_idx` equals `dst_idx + vec_len` modulo 128.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The outputs of that operation are present in the same cycle.
- R8: A synchronous active-high `rst` clears `out_valid` at the next clock edge, even if `in_valid` is high.
- R9: A cycle with `in_valid` low leaves `lo_word`, `hi_word` and `dst2_idx` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 64 | First multiplicand |
| op_b | input | 64 | Second multiplicand |
| op_c | input | 64 | Value the product is subtracted from |
| dst_idx | input | 7 | Primary destination index |
| vec_mode | input | 1 | 1 = vector offset, 0 = scalar offset |
| vec_len | input | 7 | Vector length used as the offset in vector mode |
| lo_word | output | 64 | Low half of the difference |
| hi_word | output | 64 | High half of the difference |
| dst2_idx | output | 7 | Second destination index |
| out_valid | output | 1 | Result strobe |

## Verification
The bench goes after the borrow case, where `c` is smaller than the product. Here the result must become all ones in the high word. A design that kept only 64 bits, or that subtracted in the wrong direction, would show zero or a positive value there.

All-ones operands check that the product is unsigned. A signed multiplier would return 1 instead of a huge value, and the high word would come out wrong.

Index tests at 127 in scalar mode and at 100 + 50 in vector mode check the modulo-128 wrap and the mode select. A design that swapped the two modes would give the wrong index.

The bench also asserts reset while a strobe is high, and changes inputs while no strobe is present. A design that gave the strobe priority over reset, or that loaded its data registers freely, would then be caught.

// File: rtl/wide_msub_unit.sv
module wide_msub_unit #(
  parameter int DW = 64,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] op_c,
  input  logic [IW-1:0] dst_idx,
  input  logic          vec_mode,
  input  logic [IW-1:0] vec_len,
  output logic [DW-1:0] lo_word,
  output logic [DW-1:0] hi_word,
  output logic [IW-1:0] dst2_idx,
  output logic          out_valid
);
  localparam int RW = 2 * DW;

  logic [RW-1:0] prod, diff;
  logic [IW-1:0] offset;

  assign prod   = {{DW{1'b0}}, op_a} * {{DW{1'b0}}, op_b};
  assign diff   = {{DW{1'b0}}, op_c} - prod;
  assign offset = vec_mode ? vec_len : IW'(1);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      lo_word  <= diff[DW-1:0];
      hi_word  <= diff[RW-1:DW];
      dst2_idx <= dst_idx + offset;
    end
  end
endmodule

// File: rtl/wide_msub_unit_chk.sv
module wide_msub_unit_chk #(
  parameter int DW = 64,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [DW-1:0] op_c,
  input logic [IW-1:0] dst_idx,
  input logic          vec_mode,
  input logic [IW-1:0] vec_len,
  input logic [DW-1:0] lo_word,
  input logic [DW-1:0] hi_word,
  input logic [IW-1:0] dst2_idx,
  input logic          out_valid
);
  logic [DW-1:0] pa, pb, pc;
  logic [IW-1:0] pidx, plen;
  logic [2*DW-1:0] recon;

  always_ff @(posedge clk) begin
    pa <= op_a; pb <= op_b; pc <= op_c;
    pidx <= dst_idx; plen <= vec_len;
  end

  assign recon = {hi_word, lo_word} + ({{DW{1'b0}}, pa} * {{DW{1'b0}}, pb});

  // R1 R2 R3 R4: result plus product gives back c
  a_r2_identity: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> recon == {{DW{1'b0}}, pc});

  a_r5_scalar_idx: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !vec_mode) |=> dst2_idx == IW'(pidx + 1'b1));

  a_r6_vector_idx: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vec_mode) |=> dst2_idx == IW'(pidx + plen));

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(lo_word) && $stable(hi_word) && $stable(dst2_idx)));
endmodule

bind wide_msub_unit wide_msub_unit_chk #(.DW(DW), .IW(IW)) i_chk (.*);

// File: tb/test_wide_msub_unit.sv
module test_wide_msub_unit;
  logic        clk = 1'b0;
  logic        rst, in_valid, vec_mode;
  logic [63:0] op_a, op_b, op_c;
  logic [6:0]  dst_idx, vec_len;
  logic [63:0] lo_word, hi_word;
  logic [6:0]  dst2_idx;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wide_msub_unit i_wide_msub_unit (.*);

  localparam int NV = 8;
  localparam logic [63:0] TA [NV] = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd7,
    64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0000, 64'd1, 64'hDEAD_BEEF_0000_0001};
  localparam logic [63:0] TB [NV] = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd6,
    64'h0FED_CBA9_8765_4321, 64'd2, 64'd0, 64'hFFFF_0000_FFFF_0000};
  localparam logic [63:0] TC [NV] = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'd100,
    64'd0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
  localparam logic [6:0] TD [NV] = '{7'd0, 7'd127, 7'd5, 7'd100, 7'd64, 7'd1, 7'd126, 7'd10};
  localparam logic       TM [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [6:0] TL [NV] = '{7'd8, 7'd3, 7'd8, 7'd50, 7'd127, 7'd9, 7'd0, 7'd4};

  function automatic logic [127:0] ref_diff(logic [63:0] a, logic [63:0] b, logic [63:0] c);
    logic [127:0] p;
    p = {64'd0, a} * {64'd0, b};
    return {64'd0, c} - p;
  endfunction

  function automatic logic [6:0] ref_idx(logic [6:0] d, logic m, logic [6:0] l);
    return m ? 7'(d + l) : 7'(d + 7'd1);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [63:0] c,
                       logic [6:0] d, logic m, logic [6:0] l, logic v);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; dst_idx = d; vec_mode = m; vec_len = l; in_valid = v;
  endtask

  task automatic run_op(string req, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                        logic [6:0] d, logic m, logic [6:0] l);
    logic [127:0] e;
    e = ref_diff(a, b, c);
    drive(a, b, c, d, m, l, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R7 valid"}, 128'(out_valid), 128'd1);
    chk({req, " R3 lo"}, 128'(lo_word), 128'(e[63:0]));
    chk({req, " R4 hi"}, 128'(hi_word), 128'(e[127:64]));
    chk({req, m ? " R6 idx" : " R5 idx"}, 128'(dst2_idx), 128'(ref_idx(d, m, l)));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; vec_mode = 1'b0;
    op_a = '0; op_b = '0; op_c = '0; dst_idx = '0; vec_len = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset state", 128'(out_valid), 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 idle no valid", 128'(out_valid), 128'd0);

    for (int i = 0; i < NV; i++)
      run_op("R1 R2 table", TA[i], TB[i], TC[i], TD[i], TM[i], TL[i]);

    // R2 borrow: 5 - 6 wraps to all ones
    run_op("R2 borrow", 64'd2, 64'd3, 64'd5, 7'd0, 1'b0, 7'd0);
    chk("R2 borrow hi", 128'(hi_word), 128'(64'hFFFF_FFFF_FFFF_FFFF));
    chk("R2 borrow lo", 128'(lo_word), 128'(64'hFFFF_FFFF_FFFF_FFFF));

    // R1 unsigned all-ones: hi = 2, lo = ...FE
    run_op("R1 all ones", '1, '1, '1, 7'd127, 1'b0, 7'd0);
    chk("R1 all ones hi", 128'(hi_word), 128'(64'd2));
    chk("R1 all ones lo", 128'(lo_word), 128'(64'hFFFF_FFFF_FFFF_FFFE));
    chk("R5 wrap 127+1", 128'(dst2_idx), 128'(7'd0));

    run_op("R6 wrap", 64'd4, 64'd4, 64'd16, 7'd100, 1'b1, 7'd50);
    chk("R6 wrap 100+50", 128'(dst2_idx), 128'(7'd22));
    chk("R2 zero diff", {hi_word, lo_word}, 128'd0);

    // R9: change inputs without strobe, outputs hold
    drive(64'd99, 64'd99, 64'd1, 7'd3, 1'b1, 7'd9, 1'b0);
    @(negedge clk);
    chk("R9 hold lo", 128'(lo_word), 128'd0);
    chk("R9 hold hi", 128'(hi_word), 128'd0);
    chk("R9 hold idx", 128'(dst2_idx), 128'(7'd22));
    chk("R7 no valid without strobe", 128'(out_valid), 128'd0);

    for (int i = 0; i < 40; i++)
      run_op("R1 R2 random", {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             7'($urandom), 1'($urandom), 7'($urandom));

    // R8: reset wins over strobe
    drive(64'd1, 64'd1, 64'd1, 7'd1, 1'b0, 7'd1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset over strobe", 128'(out_valid), 128'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R8 after reset", 128'(out_valid), 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule